// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Receiver

This block is the host side of a one-bit read over a shared open-drain debug line. When the caller asks for a bit, the block pulls the line low to open a bit time. It lets the line go again well before the target can send its rising-edge speed-up pulse. It then reads the line at a fixed point, where a target sending zero is still holding it low and a target sending one has let it float high. Last, it keeps the line released for the rest of a fixed bit slot before it reports the result.

All timing is counted in target-clock periods. The caller supplies these as a one-cycle clock-enable tick in the host clock domain, and any tick spacing works. The pin input is expected to be synchronised already. The output-enable pulls the open-drain line low when it is high. Framing of several bits into commands belongs to the caller, which issues one start request per bit.

Top module: `dbgBitReceiver`

## Requirements
- R1: A synchronous active-high reset clears the line output-enable, the done strobe and the received bit to 0, including when a bit is in progress.
- R2: A start request seen on a clock edge while the block is idle is accepted, and the output-enable is 1 in the following clock cycle.
- R3: After acceptance the output-enable stays 1 for exactly DRIVE_TICKS (default 4) ticks and then returns to 0. The timing depends only on the number of ticks, not on their spacing in clock cycles.
- R4: The bit is captured on the edge of the SAMPLE_TICK-th tick (default 10th) after acceptance. The pin level present between the 9th and 10th tick decides the bit, and a level only in the 8th-to-9th or 10th-to-11th tick interval does not.
- R5: A high pin at the sample point yields a received bit of 1. A target that holds the line low for 13 ticks yields 0.
- R6: The done strobe is high for exactly one clock cycle, in the cycle after the BIT_TICKS-th tick (default 16th). The output-enable stays 0 from the end of the drive until done.
- R7: A start request that arrives while a bit is in progress is ignored. This includes one that coincides with the final tick, and no extra bit time follows it.
- R8: A start request in the same cycle as the done strobe is accepted as a new bit.
- R9: The received bit keeps its value from the done strobe until the next sample point, whatever the pin does in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable marking one target clock period |
| startReq | input | 1 | Request to read one bit |
| pinIn | input | 1 | Synchronised level of the shared line |
| pinOe | output | 1 | 1 pulls the open-drain line low |
| rxBit | output | 1 | Last bit received (1 = line high at the sample point) |
| doneStb | output | 1 | One-cycle pulse when the bit slot has ended |

## Verification
Two events can fall in the same cycle: ending a bit slot and receiving a new start request. The first pairing asserts a start request on the clock edge that carries the final tick. That request must be dropped: the bench watches the output-enable for twenty cycles after done and expects it to stay 0. The second pairing raises a start request while the done strobe is high. That request must open a new bit, and the output-enable must be 1 one cycle later. Both come from the same bench target model, which counts ticks on its own.

// File: rtl/dbgBitRxPkg.sv
package dbgBitRxPkg;

  // strobes issued by the sequencer to the timing datapath
  typedef struct packed {
    logic clear;    // restart the tick counter at a new bit
    logic advance;  // count one target period
    logic sample;   // capture the line level
  } rxStrobes_t;

  // position flags reported by the datapath
  typedef struct packed {
    logic driveLast;  // current tick ends the low drive
    logic sampleHit;  // current tick is the sample point
    logic slotEnd;    // current tick closes the bit slot
  } rxFlags_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRIVE  = 2'd1,
    ST_LISTEN = 2'd2,
    ST_HOLD   = 2'd3
  } rxState_t;

endpackage

// File: rtl/dbgBitRxPath.sv
module dbgBitRxPath
  import dbgBitRxPkg::*;
#(
  parameter int DRIVE_TICKS = 4,
  parameter int SAMPLE_TICK = 10,
  parameter int BIT_TICKS   = 16,
  localparam int CNT_W      = $clog2(BIT_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  rxStrobes_t       strb,
  input  logic             pinIn,
  output rxFlags_t         flags,
  output logic [CNT_W-1:0] tickCount,
  output logic             rxBit
);

  localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_TICKS - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_TICK - 1);
  localparam logic [CNT_W-1:0] SLOT_LAST   = CNT_W'(BIT_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCount <= '0;
    end else if (strb.clear) begin
      tickCount <= '0;
    end else if (strb.advance) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxBit <= 1'b0;
    end else if (strb.sample) begin
      rxBit <= pinIn;
    end
  end

  always_comb begin
    flags.driveLast = (tickCount == DRIVE_LAST);
    flags.sampleHit = (tickCount == SAMPLE_LAST);
    flags.slotEnd   = (tickCount == SLOT_LAST);
  end

endmodule

// File: rtl/dbgBitRxCtrl.sv
module dbgBitRxCtrl
  import dbgBitRxPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       startReq,
  input  rxFlags_t   flags,
  output rxStrobes_t strb,
  output logic       pinOe,
  output logic       doneStb
);

  rxState_t state;
  rxState_t nextState;
  logic     slotClose;

  always_comb begin
    nextState    = state;
    strb         = '0;
    slotClose    = 1'b0;
    strb.advance = tick && (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.clear = 1'b1;
          nextState  = ST_DRIVE;
        end
      end
      ST_DRIVE: begin
        if (tick && flags.driveLast) nextState = ST_LISTEN;
      end
      ST_LISTEN: begin
        if (tick && flags.sampleHit) begin
          strb.sample = 1'b1;
          nextState   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tick && flags.slotEnd) begin
          slotClose = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      doneStb <= 1'b0;
    end else begin
      state   <= nextState;
      doneStb <= slotClose;
    end
  end

  assign pinOe = (state == ST_DRIVE);

endmodule

// File: rtl/dbgBitReceiver.sv
module dbgBitReceiver
  import dbgBitRxPkg::*;
#(
  parameter int DRIVE_TICKS = 4,
  parameter int SAMPLE_TICK = 10,
  parameter int BIT_TICKS   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic startReq,
  input  logic pinIn,
  output logic pinOe,
  output logic rxBit,
  output logic doneStb
);

  localparam int CNT_W = $clog2(BIT_TICKS + 1);

  rxStrobes_t       strb;
  rxFlags_t         flags;
  logic [CNT_W-1:0] tickCount;

  dbgBitRxCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .startReq (startReq),
    .flags    (flags),
    .strb     (strb),
    .pinOe    (pinOe),
    .doneStb  (doneStb)
  );

  dbgBitRxPath #(
    .DRIVE_TICKS (DRIVE_TICKS),
    .SAMPLE_TICK (SAMPLE_TICK),
    .BIT_TICKS   (BIT_TICKS)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .pinIn     (pinIn),
    .flags     (flags),
    .tickCount (tickCount),
    .rxBit     (rxBit)
  );

endmodule

// File: rtl/dbgBitReceiverChecker.sv
module dbgBitReceiverChecker
  import dbgBitRxPkg::*;
#(
  parameter int DRIVE_TICKS = 4,
  parameter int SAMPLE_TICK = 10,
  parameter int BIT_TICKS   = 16,
  localparam int CNT_W      = $clog2(BIT_TICKS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             startReq,
  input logic             pinOe,
  input logic             rxBit,
  input logic             doneStb,
  input rxStrobes_t       strb,
  input logic [CNT_W-1:0] tickCount
);

  // R2: the line is only pulled after a request
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pinOe) |-> $past(startReq));

  // R3: drive never extends past its tick budget
  p_drive_window_r3: assert property (@(posedge clk) disable iff (rst)
    pinOe |-> (tickCount < CNT_W'(DRIVE_TICKS)));

  // R4: capture strobe only on the sample tick
  p_sample_point_r4: assert property (@(posedge clk) disable iff (rst)
    strb.sample |-> (tick && tickCount == CNT_W'(SAMPLE_TICK - 1)));

  // R6: done is a single-cycle pulse with the line released
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    doneStb |=> !doneStb);

  p_done_released_r6: assert property (@(posedge clk) disable iff (rst)
    doneStb |-> !pinOe);

  // R9: received bit only moves after a capture strobe
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.sample |=> $stable(rxBit));

endmodule

bind dbgBitReceiver dbgBitReceiverChecker #(
  .DRIVE_TICKS (DRIVE_TICKS),
  .SAMPLE_TICK (SAMPLE_TICK),
  .BIT_TICKS   (BIT_TICKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .startReq  (startReq),
  .pinOe     (pinOe),
  .rxBit     (rxBit),
  .doneStb   (doneStb),
  .strb      (strb),
  .tickCount (tickCount)
);

// File: tb/dbgBitReceiver_tb.sv
module dbgBitReceiver_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic startReq = 1'b0;
  logic pinIn = 1'b1;
  logic pinOe;
  logic rxBit;
  logic doneStb;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  dbgBitReceiver u_dut (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .startReq (startReq),
    .pinIn    (pinIn),
    .pinOe    (pinOe),
    .rxBit    (rxBit),
    .doneStb  (doneStb)
  );

  // {mode[2:0], tickDiv[2:0], expectedBit}
  // mode 0: target releases (one); 1: target low 13 ticks (zero);
  // 2: low only in tick interval 9; 3: only interval 8; 4: only interval 10
  localparam logic [6:0] VEC [8] = '{
    {3'd0, 3'd1, 1'b1},
    {3'd1, 3'd1, 1'b0},
    {3'd1, 3'd3, 1'b0},
    {3'd0, 3'd2, 1'b1},
    {3'd2, 3'd2, 1'b0},
    {3'd3, 3'd2, 1'b1},
    {3'd4, 3'd2, 1'b1},
    {3'd1, 3'd4, 1'b0}
  };

  function automatic logic targetPull(input int mode, input int cnt);
    case (mode)
      1:       return cnt < 13;
      2:       return cnt == 9;
      3:       return cnt == 8;
      4:       return cnt == 10;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Runs one bit; caller is at a negedge. startNow=0 means startReq is already high.
  task automatic runBit(input int mode, input int div, input logic expBit,
                        input logic poke, input logic chain, input logic startNow,
                        input string acceptTag);
    int cnt = 0;
    int phase = 0;
    int oeTicks = 0;
    logic seenDone = 1'b0;
    logic tk;
    logic oeNow;
    if (startNow) startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    check(pinOe === 1'b1, acceptTag, int'(pinOe), 1);
    for (int it = 0; it < 400 && !seenDone; it++) begin
      tk = (phase == div - 1);
      phase = tk ? 0 : phase + 1;
      tick = tk;
      oeNow = pinOe;
      pinIn = !(pinOe || targetPull(mode, cnt));
      startReq = poke && ((cnt == 5) || (cnt == 15 && tk));
      @(posedge clk);
      if (tk) begin
        cnt++;
        if (oeNow) oeTicks++;
      end
      @(negedge clk);
      tick = 1'b0;
      startReq = 1'b0;
      if (pinOe && cnt >= 4) check(1'b0, "R6 line released after drive", cnt, 4);
      if (doneStb) seenDone = 1'b1;
    end
    check(seenDone && cnt == 16, "R6 done after 16th tick", cnt, 16);
    check(oeTicks == 4, "R3 drive length in ticks", oeTicks, 4);
    check(rxBit === expBit, (mode == 1) ? "R5 received bit" : "R4 received bit",
          int'(rxBit), int'(expBit));
    pinIn = 1'b1;
    if (chain) begin
      startReq = 1'b1;  // same cycle as done: R8
    end else begin
      @(negedge clk);
      check(doneStb === 1'b0, "R6 done width", int'(doneStb), 0);
      for (int k = 0; k < 20; k++) begin
        tick = (k % 2 == 0);
        pinIn = (k % 3 == 0);
        @(negedge clk);
        if (pinOe !== 1'b0) check(1'b0, "R7 no extra bit time", int'(pinOe), 0);
        if (rxBit !== expBit) check(1'b0, "R9 received bit held", int'(rxBit), int'(expBit));
      end
      check(pinOe === 1'b0, poke ? "R7 busy request ignored" : "R9 idle", int'(pinOe), 0);
      check(rxBit === expBit, "R9 received bit held after idle pin activity", int'(rxBit), int'(expBit));
      tick = 1'b0;
      pinIn = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pinOe === 1'b0 && doneStb === 1'b0 && rxBit === 1'b0, "R1 reset state",
          int'({pinOe, doneStb, rxBit}), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      runBit(int'(VEC[i][6:4]), int'(VEC[i][3:1]), VEC[i][0], i[0], 1'b0, 1'b1,
             "R2 drive after start");
    end

    // R8: start coinciding with done opens the next bit
    runBit(0, 2, 1'b1, 1'b0, 1'b1, 1'b1, "R2 drive after start");
    runBit(1, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R8 start in done cycle accepted");

    // R1: reset in the middle of a bit (after a one has been received)
    runBit(0, 1, 1'b1, 1'b0, 1'b0, 1'b1, "R2 drive after start");
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    tick = 1'b1;
    repeat (2) @(negedge clk);
    tick = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(pinOe === 1'b0 && doneStb === 1'b0 && rxBit === 1'b0, "R1 reset mid-bit",
          int'({pinOe, doneStb, rxBit}), 0);
    rst = 1'b0;
    @(negedge clk);
    runBit(1, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R2 drive after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule